// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs single read and write cycles on an external bus whose 16 shared lines carry first an address and then data. It drives three strobes: an active-high address latch, an active-low read and an active-low write. The pads are modelled as a separate output value, an output enable and an input value. A host hands over one access at a time through a request/ready handshake that carries an address, write data and a write flag. The block answers with a one-clock done pulse and, for reads, the sampled data.

The block keeps the address last placed in the external latch. When the next access, read or write, targets that same address, the latch phase is skipped and the access goes straight to its data phase. The cached address starts as zero and is marked valid, so a first access to address zero runs no latch phase. A flush input marks the cache invalid, which forces the next access to latch its address. The length of every strobe is set per access by a runtime delay input, counted in clock cycles.

An access cannot be interrupted. The latch phase, if needed, and the data phase run as one unit, and no new request is taken until the done pulse has been given.

Top module: `muxbus_master`

## Requirements
- R1: After reset and whenever idle, aleOut is 0, rdN and wrN are 1, rspDone is 0 and reqReady is 1.
- R2: After reset the cached address is 0 and valid, so an access to address 0 issued first runs no latch pulse.
- R3: On a cache miss, aleOut is high for exactly D cycles with busOe=1 and the requested address on busOut. In the first cycle after aleOut falls, busOut is 0. The external latch therefore holds the requested address.
- R4: On a read, busOe is 0 for at least one cycle before rdN falls and stays 0 while rdN is low. rdN is low for exactly D cycles, and rspData returns the busIn value seen in the last low cycle.
- R5: On a write, busOe is 1 and busOut equals the write data, unchanged, in every cycle wrN is low. wrN is low for exactly D cycles.
- R6: When the cache is valid and holds the requested address, reads and writes both run with no latch pulse.
- R7: rdN and wrN are never low together, and neither is low while aleOut is high.
- R8: reqReady is 1 only while idle. A request is taken only on a cycle with reqValid and reqReady both 1. Request inputs that change or stay asserted while busy have no effect on the running access.
- R9: rspDone is high for exactly one cycle per access. rspData keeps the last read value until the next read completes, so a write leaves it unchanged.
- R10: A one-cycle pulse on flush makes the next access run the latch phase, even for the cached address.
- R11: A flush in the same cycle the latch phase completes takes priority over the cache update: the next access to that same address latches again.
- R12: D is the strobeDly value captured when the request is taken. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | BUS_W | Access address |
| reqWdata | input | BUS_W | Write data |
| strobeDly | input | DLY_W | Strobe length in cycles (0 treated as 1) |
| flush | input | 1 | Invalidate the cached address |
| rspDone | output | 1 | One-cycle end-of-access pulse |
| rspData | output | BUS_W | Last read data |
| busOut | output | BUS_W | Value driven on the shared lines |
| busOe | output | 1 | Output enable for the shared lines |
| busIn | input | BUS_W | Value seen on the shared lines |
| aleOut | output | 1 | Address latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |

## Verification
A flush and the cache update at the end of a latch phase can land on the same clock edge. The bench provokes this by counting latch-high cycles during a two-cycle latch phase and raising flush in the second, final one. The outcome is judged at the ports: the next write to the same address must show a fresh latch pulse, and the device model must receive the data at that address.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  // Commands from the sequencer to the shared-line driver
  typedef enum logic [2:0] {
    BUS_HOLD,
    BUS_ADDR,
    BUS_ZERO_OUT,
    BUS_ZERO_IN,
    BUS_DATA
  } busCmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_PREP,
    ST_STROBE,
    ST_FIN
  } seqState_e;

  typedef struct packed {
    logic    capture;
    busCmd_e busCmd;
    logic    cacheLoad;
    logic    sample;
  } dpCmd_t;

endpackage

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [DLY_W-1:0] strobeDly,
  input  logic             addrHit,
  output logic             reqReady,
  output logic             rspDone,
  output logic             aleOut,
  output logic             rdN,
  output logic             wrN,
  output dpCmd_t           dpCmd
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  seqState_e        stateQ, stateD;
  logic [DLY_W-1:0] cntQ;
  logic [DLY_W-1:0] dlyQ;
  logic [DLY_W-1:0] effDly;
  logic             writeQ;
  logic             accept;

  assign effDly = (strobeDly == '0) ? ONE : strobeDly;
  assign accept = (stateQ == ST_IDLE) && reqValid;

  always_comb begin
    stateD           = stateQ;
    dpCmd            = '0;
    dpCmd.busCmd     = BUS_HOLD;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          dpCmd.capture = 1'b1;
          if (!addrHit) begin
            stateD       = ST_LATCH;
            dpCmd.busCmd = BUS_ADDR;
          end else begin
            stateD       = ST_PREP;
            dpCmd.busCmd = reqWrite ? BUS_ZERO_OUT : BUS_ZERO_IN;
          end
        end
      end
      ST_LATCH: begin
        if (cntQ == '0) begin
          stateD          = ST_PREP;
          dpCmd.cacheLoad = 1'b1;
          dpCmd.busCmd    = writeQ ? BUS_ZERO_OUT : BUS_ZERO_IN;
        end
      end
      ST_PREP: begin
        stateD = ST_STROBE;
        if (writeQ) dpCmd.busCmd = BUS_DATA;
      end
      ST_STROBE: begin
        if (cntQ == '0) begin
          stateD       = ST_FIN;
          dpCmd.sample = !writeQ;
        end
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      dlyQ   <= ONE;
      writeQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) begin
        writeQ <= reqWrite;
        dlyQ   <= effDly;
      end
      if (accept && !addrHit) begin
        cntQ <= effDly - ONE;
      end else if (stateQ == ST_PREP) begin
        cntQ <= dlyQ - ONE;
      end else if ((stateQ == ST_LATCH || stateQ == ST_STROBE) && cntQ != '0) begin
        cntQ <= cntQ - ONE;
      end
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign rspDone  = (stateQ == ST_FIN);
  assign aleOut   = (stateQ == ST_LATCH);
  assign rdN      = !((stateQ == ST_STROBE) && !writeQ);
  assign wrN      = !((stateQ == ST_STROBE) && writeQ);

  // Independent up-counter of the current strobe run, for the length check
  logic [DLY_W:0] runLenQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLenQ <= '0;
    else if (stateQ == ST_LATCH || stateQ == ST_STROBE) runLenQ <= runLenQ + 1'b1;
    else runLenQ <= '0;
  end

  // R3 R12
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_PREP || stateQ == ST_FIN) &&
     ($past(stateQ) == ST_LATCH || $past(stateQ) == ST_STROBE))
    |-> (runLenQ == {1'b0, dlyQ}));

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |=> !($past(dpCmd.capture)));

endmodule

// File: rtl/muxbus_dpath.sv
module muxbus_dpath
  import muxbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic             flush,
  input  dpCmd_t           dpCmd,
  input  logic [BUS_W-1:0] busIn,
  output logic             addrHit,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  output logic [BUS_W-1:0] rspData
);

  logic [BUS_W-1:0] addrQ, wdataQ, cachedAddrQ, busOutQ, rdataQ;
  logic             cacheValidQ, busOeQ;

  assign addrHit = cacheValidQ && (reqAddr == cachedAddrQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (dpCmd.capture) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  // Shared-line driver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOutQ <= '0;
      busOeQ  <= 1'b0;
    end else begin
      case (dpCmd.busCmd)
        BUS_ADDR:     begin busOutQ <= reqAddr; busOeQ <= 1'b1; end
        BUS_ZERO_OUT: begin busOutQ <= '0;      busOeQ <= 1'b1; end
        BUS_ZERO_IN:  begin busOutQ <= '0;      busOeQ <= 1'b0; end
        BUS_DATA:     begin busOutQ <= wdataQ;  busOeQ <= 1'b1; end
        default:      begin end
      endcase
    end
  end

  // Address cache: flush outranks a simultaneous update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cachedAddrQ <= '0;
      cacheValidQ <= 1'b1;
    end else begin
      if (dpCmd.cacheLoad) cachedAddrQ <= addrQ;
      if (flush) cacheValidQ <= 1'b0;
      else if (dpCmd.cacheLoad) cacheValidQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else if (dpCmd.sample) rdataQ <= busIn;
  end

  assign busOut  = busOutQ;
  assign busOe   = busOeQ;
  assign rspData = rdataQ;

  // R10 R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !addrHit);

endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
  import muxbus_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic [DLY_W-1:0] strobeDly,
  input  logic             flush,
  output logic             rspDone,
  output logic [BUS_W-1:0] rspData,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  input  logic [BUS_W-1:0] busIn,
  output logic             aleOut,
  output logic             rdN,
  output logic             wrN
);

  dpCmd_t dpCmd;
  logic   addrHit;

  muxbus_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .strobeDly(strobeDly), .addrHit(addrHit), .reqReady(reqReady),
    .rspDone(rspDone), .aleOut(aleOut), .rdN(rdN), .wrN(wrN), .dpCmd(dpCmd)
  );

  muxbus_dpath #(.BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .flush(flush), .dpCmd(dpCmd), .busIn(busIn), .addrHit(addrHit),
    .busOut(busOut), .busOe(busOe), .rspData(rspData)
  );

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN) && !(aleOut && (!rdN || !wrN)));

  // R4
  rd_bus_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !busOe);

  // R4
  oe_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> !$past(busOe));

  // R3
  ale_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |-> busOe);

  // R5
  wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && !$past(wrN)) |-> ($stable(busOut) && busOe));

  // R1 R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!aleOut && rdN && wrN && !rspDone));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

// File: tb/muxbus_master_bench.sv
module muxbus_master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, flush = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic [7:0]  strobeDly = 8'd1;
  logic        reqReady, rspDone, busOe, aleOut, rdN, wrN;
  logic [15:0] rspData, busOut, busIn;

  always #10 clk = ~clk;

  muxbus_master u_muxbus_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .strobeDly(strobeDly), .flush(flush), .rspDone(rspDone), .rspData(rspData),
    .busOut(busOut), .busOe(busOe), .busIn(busIn), .aleOut(aleOut),
    .rdN(rdN), .wrN(wrN)
  );

  int errors = 0;
  int checks = 0;

  // Device model and bus monitors
  logic [15:0] mem [256];
  logic [15:0] latchReg = '0;
  logic [15:0] zeroAfter = 16'hFFFF;
  int aleRun = 0, rdRun = 0, wrRun = 0;
  int lastAleLen = 0, lastRdLen = 0, lastWrLen = 0;
  int aleCount = 0, doneCount = 0;
  int ovErr = 0, oeErr = 0, wrErr = 0;
  logic prevRdN = 1'b1, prevOe = 1'b0;

  assign busIn = rdN ? 16'h0000 : mem[latchReg[7:0]];

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    end else begin
      if (rspDone) doneCount++;
      if ((!rdN && !wrN) || (aleOut && (!rdN || !wrN))) ovErr++;
      if (aleOut) begin
        aleRun++;
        latchReg = busOut;
        if (!busOe) oeErr++;
      end else if (aleRun != 0) begin
        lastAleLen = aleRun; aleRun = 0; aleCount++; zeroAfter = busOut;
      end
      if (!rdN) begin
        rdRun++;
        if (busOe) oeErr++;
        if (prevRdN && prevOe) oeErr++;
      end else if (rdRun != 0) begin
        lastRdLen = rdRun; rdRun = 0;
      end
      if (!wrN) begin
        wrRun++;
        if (!busOe) wrErr++;
        mem[latchReg[7:0]] = busOut;
      end else if (wrRun != 0) begin
        lastWrLen = wrRun; wrRun = 0;
      end
      prevRdN = rdN;
      prevOe  = busOe;
    end
  end

  task automatic waitNeg();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-access results
  logic [15:0] xRd;
  int dAle, dDone, busyReady;

  task automatic xfer(input bit wr, input logic [15:0] a, input logic [15:0] d,
                      input logic [7:0] dly, input bit holdReq);
    int a0, d0, n;
    a0 = aleCount; d0 = doneCount; busyReady = 0; n = 0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; strobeDly = dly;
    while (!reqReady) waitNeg();
    waitNeg();
    if (holdReq) begin
      reqAddr = a ^ 16'h00F0; reqWdata = ~d; strobeDly = 8'd7;
    end else reqValid = 1'b0;
    while (!rspDone && n < 2000) begin
      if (reqReady) busyReady++;
      waitNeg(); n++;
    end
    xRd = rspData;
    reqValid = 1'b0;
    waitNeg();
    chk(!rspDone, "R9 done one cycle", rspDone, 0);
    dAle = aleCount - a0; dDone = doneCount - d0;
  endtask

  task automatic t_reset();
    chk(aleOut == 0 && rdN && wrN, "R1 strobes idle", {aleOut, rdN, wrN}, 3'b011);
    chk(reqReady && !rspDone, "R1 ready/done", {reqReady, rspDone}, 2'b10);
  endtask

  task automatic t_first_zero();
    xfer(1'b1, 16'h0000, 16'hA5A5, 8'd2, 1'b0);
    chk(dAle == 0, "R2 no latch for addr 0 write", dAle, 0);
    chk(lastWrLen == 2, "R5 write strobe length", lastWrLen, 2);
    chk(mem[8'h00] == 16'hA5A5, "R5 write data", mem[8'h00], 16'hA5A5);
    xfer(1'b0, 16'h0000, 16'h0000, 8'd2, 1'b0);
    chk(dAle == 0, "R2 no latch for addr 0 read", dAle, 0);
    chk(xRd == 16'hA5A5, "R4 read data", xRd, 16'hA5A5);
    chk(lastRdLen == 2, "R4 read strobe length", lastRdLen, 2);
  endtask

  task automatic t_miss_write();
    xfer(1'b1, 16'h1234, 16'hBEEF, 8'd3, 1'b0);
    chk(dAle == 1, "R3 one latch pulse", dAle, 1);
    chk(lastAleLen == 3, "R3 latch length", lastAleLen, 3);
    chk(latchReg == 16'h1234, "R3 latched address", latchReg, 16'h1234);
    chk(zeroAfter == 16'h0000, "R3 lines zero after latch", zeroAfter, 0);
    chk(lastWrLen == 3 && mem[8'h34] == 16'hBEEF, "R5 miss write", mem[8'h34], 16'hBEEF);
  endtask

  task automatic t_hit_read();
    xfer(1'b0, 16'h1234, 16'h0000, 8'd3, 1'b0);
    chk(dAle == 0, "R6 read hit skips latch", dAle, 0);
    chk(xRd == 16'hBEEF && lastRdLen == 3, "R4 hit read data", xRd, 16'hBEEF);
  endtask

  task automatic t_miss_read();
    xfer(1'b0, 16'h0000, 16'h0000, 8'd1, 1'b0);
    chk(dAle == 1 && lastAleLen == 1, "R3 miss read latch", lastAleLen, 1);
    chk(xRd == 16'hA5A5 && lastRdLen == 1, "R4 miss read data", xRd, 16'hA5A5);
  endtask

  task automatic t_hold_rdata();
    xfer(1'b1, 16'h0000, 16'h1111, 8'd1, 1'b0);
    chk(dAle == 0, "R6 write hit skips latch", dAle, 0);
    chk(rspData == 16'hA5A5, "R9 rdata kept over write", rspData, 16'hA5A5);
    chk(dDone == 1, "R9 one done per access", dDone, 1);
  endtask

  task automatic t_busy_ignore();
    xfer(1'b1, 16'h2256, 16'h7E57, 8'd2, 1'b1);
    chk(busyReady == 0, "R8 ready low while busy", busyReady, 0);
    chk(dDone == 1, "R8 single accept", dDone, 1);
    chk(latchReg == 16'h2256 && mem[8'h56] == 16'h7E57, "R8 busy inputs ignored",
        mem[8'h56], 16'h7E57);
    chk(lastWrLen == 2, "R8 delay change ignored", lastWrLen, 2);
    xfer(1'b0, 16'h2256, 16'h0000, 8'd2, 1'b0);
    chk(dAle == 0 && xRd == 16'h7E57, "R6 hit after held request", xRd, 16'h7E57);
  endtask

  task automatic t_flush();
    flush = 1'b1; waitNeg(); flush = 1'b0;
    xfer(1'b0, 16'h2256, 16'h0000, 8'd2, 1'b0);
    chk(dAle == 1, "R10 flush forces latch", dAle, 1);
    chk(xRd == 16'h7E57, "R10 read after flush", xRd, 16'h7E57);
  endtask

  task automatic t_collision();
    fork
      xfer(1'b1, 16'h3378, 16'h0C0C, 8'd2, 1'b0);
      begin
        int seen;
        seen = 0;
        while (seen < 2) begin
          waitNeg();
          if (aleOut) seen++;
        end
        flush = 1'b1; waitNeg(); flush = 1'b0;
      end
    join
    chk(mem[8'h78] == 16'h0C0C, "R11 write with flush", mem[8'h78], 16'h0C0C);
    xfer(1'b1, 16'h3378, 16'h0D0D, 8'd2, 1'b0);
    chk(dAle == 1, "R11 flush beats cache update", dAle, 1);
    chk(mem[8'h78] == 16'h0D0D, "R11 data after relatch", mem[8'h78], 16'h0D0D);
  endtask

  task automatic t_zero_delay();
    xfer(1'b0, 16'h3378, 16'h0000, 8'd0, 1'b0);
    chk(dAle == 0 && lastRdLen == 1, "R12 zero delay read", lastRdLen, 1);
    chk(xRd == 16'h0D0D, "R12 zero delay read data", xRd, 16'h0D0D);
    xfer(1'b1, 16'h4400, 16'h5A5A, 8'd0, 1'b0);
    chk(dAle == 1 && lastAleLen == 1, "R12 zero delay latch", lastAleLen, 1);
    chk(lastWrLen == 1 && mem[8'h00] == 16'h5A5A, "R12 zero delay write", mem[8'h00], 16'h5A5A);
    t_reset();
  endtask

  initial begin
    repeat (3) waitNeg();
    rstN = 1'b1;
    waitNeg();
    t_reset();
    t_first_zero();
    t_miss_write();
    t_hit_read();
    t_miss_read();
    t_hold_rdata();
    t_busy_ignore();
    t_flush();
    t_collision();
    t_zero_delay();
    chk(ovErr == 0, "R7 strobe overlap", ovErr, 0);
    chk(oeErr == 0, "R4 bus direction", oeErr, 0);
    chk(wrErr == 0, "R5 oe during write", wrErr, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule